// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block sits next to the control path of a small 32-bit soft processor. When the core presents an event strobe, it carries out entry into a break, a memory-management fault, a hardware exception or an external interrupt. It does this in the same clock cycle, with no wait states. For that cycle it drives the next program counter, the general register write (which register and what value), the syndrome register write, the branch-target register write and a load-reservation clear. These are all strobes plus data, and they are consumed by the register file and the fetch unit.

The block owns a 7-bit status register. The core can also write this register through a plain write port, which is used by move-to-status and return-from-exception instructions. The layout of the register is part of the behaviour:
- bit 0: interrupt enable
- bit 1: user mode
- bit 2: saved user mode
- bit 3: virtual mode
- bit 4: saved virtual mode
- bit 5: break in progress
- bit 6: exception in progress

For faults, the return address is wound back so that the interrupted branch or immediate prefix runs again. A second memory-management fault that arrives while the first is still being handled is reported as fatal and does not vector.

Top module: `exc_entry_seq`

## Requirements
- R1: On entry, `pc_nxt` is `vec_base` plus one of three offsets: 0x10 for an interrupt, 0x18 for a break, and 0x20 for a hardware exception or a memory-management fault.
- R2: An interrupt request is accepted only when all of these hold: status bit 0 is set, status bits 5 and 6 are clear, `in_dslot` is low and `after_imm` is low. Otherwise the request produces no strobe and no status change, and `irq_ok` shows this acceptance condition.
- R3: Interrupt entry writes `cur_pc` to register 14 and clears status bit 0.
- R4: Break entry writes `cur_pc` to register 16 and sets status bit 5.
- R5: Hardware exception entry writes `cur_pc`+4 to register 17, sets status bit 6, and writes `hwx_code` into syndrome bits 4:0.
- R6: Memory-management fault entry writes a return address to register 17, chosen in this order:
  - `cur_pc`-8 when in a delay slot whose branch used a prefix;
  - otherwise `cur_pc`-4 when in a delay slot or right after a prefix;
  - otherwise `cur_pc`.
- R7: The fault syndrome code depends on the fault type and on `acc_kind` (00 load, 01 store, 10 fetch):
  - translation miss: 17 for fetch, 16 for data;
  - protection fault: 19 for fetch, 18 for data.
  
  Syndrome bit 10 is set when the access was a store.
- R8: An exception or fault taken in a delay slot sets syndrome bit 12 and writes `br_tgt` to the branch-target register.
- R9: Every entry moves status bit 1 to bit 2 and bit 3 to bit 4, clears bits 1 and 3, and pulses `resv_clr`.
- R10: A memory-management fault raised after one was taken, while status bit 6 is still set, raises `fatal` and causes no write strobe and no status change.
- R11: When several events are requested together, break wins over fault, fault wins over hardware exception, and hardware exception wins over interrupt.
- R12: After reset, the status register reads zero and no strobe is active.
- R13: A status write loads `stat_wdata` when no entry happens in that cycle. Writing bit 6 as zero ends fault handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_brk | input | 1 | Break requested |
| ev_mmu | input | 1 | Memory-management fault requested |
| ev_hwx | input | 1 | Hardware exception requested |
| ev_irq | input | 1 | External interrupt requested |
| mmu_prot | input | 1 | Fault is a protection fault (else a translation miss) |
| acc_kind | input | 2 | Faulting access: 00 load, 01 store, 10 fetch |
| hwx_code | input | 5 | Hardware exception cause code |
| cur_pc | input | 32 | Address of the current instruction |
| in_dslot | input | 1 | Current instruction is in a delay slot |
| after_imm | input | 1 | Current instruction follows an immediate prefix |
| br_imm | input | 1 | The branch of this delay slot used a prefix |
| br_tgt | input | 32 | Pending branch target |
| vec_base | input | 32 | Vector base address, held stable |
| stat_wr | input | 1 | Status register write enable |
| stat_wdata | input | 7 | Status register write data |
| irq_ok | output | 1 | Interrupt acceptance condition |
| pc_wr | output | 1 | Program counter redirect strobe |
| pc_nxt | output | 32 | Redirect address |
| rf_wr | output | 1 | Register write strobe |
| rf_idx | output | 5 | Register index to write |
| rf_data | output | 32 | Return address to write |
| syn_wr | output | 1 | Syndrome register write strobe |
| syn_val | output | 32 | Syndrome value |
| btr_wr | output | 1 | Branch-target register write strobe |
| btr_val | output | 32 | Branch-target value |
| resv_clr | output | 1 | Load-reservation clear |
| fatal | output | 1 | Recursive fault detected |
| stat_o | output | 7 | Status register |

## Verification
The assertions check several rules on every cycle:
- each redirect lands on one of the three vectors;
- an interrupt redirect happens only when the acceptance condition held;
- every entry saves and clears the mode bits;
- a fatal fault writes nothing;
- a branch-target write always comes with a delay-slot syndrome;
- a simultaneous break always wins.

Only the directed scenarios can show the exact return addresses for each delay-slot and prefix combination, the syndrome codes for every access type, and the handoff in which a status write ends fault handling so that a later fault vectors normally.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XW = 32,
  parameter logic [XW-1:0] OFF_IRQ = 'h10,
  parameter logic [XW-1:0] OFF_BRK = 'h18,
  parameter logic [XW-1:0] OFF_EXC = 'h20,
  parameter int DS_BIT = 12,
  parameter int ST_BIT = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic          ev_brk,
  input  logic          ev_mmu,
  input  logic          ev_hwx,
  input  logic          ev_irq,
  input  logic          mmu_prot,
  input  logic [1:0]    acc_kind,
  input  logic [4:0]    hwx_code,
  input  logic [XW-1:0] cur_pc,
  input  logic          in_dslot,
  input  logic          after_imm,
  input  logic          br_imm,
  input  logic [XW-1:0] br_tgt,
  input  logic [XW-1:0] vec_base,
  input  logic          stat_wr,
  input  logic [6:0]    stat_wdata,
  output logic          irq_ok,
  output logic          pc_wr,
  output logic [XW-1:0] pc_nxt,
  output logic          rf_wr,
  output logic [4:0]    rf_idx,
  output logic [XW-1:0] rf_data,
  output logic          syn_wr,
  output logic [XW-1:0] syn_val,
  output logic          btr_wr,
  output logic [XW-1:0] btr_val,
  output logic          resv_clr,
  output logic          fatal,
  output logic [6:0]    stat_o
);
  localparam int S_IE = 0, S_UM = 1, S_UMS = 2, S_VM = 3, S_VMS = 4, S_BIP = 5, S_EIP = 6;
  localparam logic [4:0] R_IRQ = 5'd14, R_BRK = 5'd16, R_EXC = 5'd17;
  localparam logic [1:0] K_STORE = 2'b01, K_FETCH = 2'b10;

  logic [6:0] st;
  logic       mmu_act;
  logic       sel_brk, sel_mmu, sel_hwx, sel_irq, mmu_go, take, exc_like;
  logic [4:0] mmu_code;

  assign irq_ok  = st[S_IE] & ~st[S_BIP] & ~st[S_EIP] & ~in_dslot & ~after_imm;
  assign sel_brk = ev_valid & ev_brk;
  assign sel_mmu = ev_valid & ev_mmu & ~ev_brk;
  assign sel_hwx = ev_valid & ev_hwx & ~ev_brk & ~ev_mmu;
  assign sel_irq = ev_valid & ev_irq & ~ev_brk & ~ev_mmu & ~ev_hwx & irq_ok;
  assign mmu_go  = sel_mmu & ~mmu_act;
  assign fatal   = sel_mmu & mmu_act;
  assign exc_like = mmu_go | sel_hwx;
  assign take    = sel_brk | exc_like | sel_irq;

  assign pc_wr    = take;
  assign rf_wr    = take;
  assign resv_clr = take;
  assign syn_wr   = exc_like;
  assign btr_wr   = exc_like & in_dslot;
  assign btr_val  = br_tgt;
  assign stat_o   = st;

  assign mmu_code = {3'b100, mmu_prot, acc_kind == K_FETCH};

  always_comb begin
    pc_nxt  = vec_base + OFF_EXC;
    rf_idx  = R_EXC;
    rf_data = cur_pc;
    if (sel_brk) begin
      pc_nxt  = vec_base + OFF_BRK;
      rf_idx  = R_BRK;
    end else if (sel_irq) begin
      pc_nxt  = vec_base + OFF_IRQ;
      rf_idx  = R_IRQ;
    end else if (sel_hwx) begin
      rf_data = cur_pc + XW'(4);
    end else if (in_dslot && br_imm) begin
      rf_data = cur_pc - XW'(8);
    end else if (in_dslot || after_imm) begin
      rf_data = cur_pc - XW'(4);
    end
  end

  always_comb begin
    syn_val = '0;
    syn_val[4:0] = sel_hwx ? hwx_code : mmu_code;
    syn_val[ST_BIT] = mmu_go && acc_kind == K_STORE;
    syn_val[DS_BIT] = in_dslot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      mmu_act <= 1'b0;
    end else if (take) begin
      st[S_UMS] <= st[S_UM];
      st[S_VMS] <= st[S_VM];
      st[S_UM]  <= 1'b0;
      st[S_VM]  <= 1'b0;
      if (sel_irq)  st[S_IE]  <= 1'b0;
      if (sel_brk)  st[S_BIP] <= 1'b1;
      if (exc_like) st[S_EIP] <= 1'b1;
      if (mmu_go)   mmu_act   <= 1'b1;
    end else if (stat_wr) begin
      st <= stat_wdata;
      if (!stat_wdata[S_EIP]) mmu_act <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XW = 32,
  parameter logic [XW-1:0] OFF_IRQ = 'h10,
  parameter logic [XW-1:0] OFF_BRK = 'h18,
  parameter logic [XW-1:0] OFF_EXC = 'h20,
  parameter int DS_BIT = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic          ev_brk,
  input logic          in_dslot,
  input logic          after_imm,
  input logic [XW-1:0] vec_base,
  input logic          pc_wr,
  input logic [XW-1:0] pc_nxt,
  input logic          rf_wr,
  input logic [4:0]    rf_idx,
  input logic          syn_wr,
  input logic [XW-1:0] syn_val,
  input logic          btr_wr,
  input logic          fatal,
  input logic [6:0]    stat_o
);
  p_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |-> (pc_nxt == vec_base + OFF_IRQ || pc_nxt == vec_base + OFF_BRK || pc_nxt == vec_base + OFF_EXC));

  p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && rf_idx == 5'd14) |-> (stat_o[0] && !stat_o[5] && !stat_o[6] && !in_dslot && !after_imm));

  p_irq_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && rf_idx == 5'd14) |=> !stat_o[0]);

  p_brk_bip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && rf_idx == 5'd16) |=> stat_o[5]);

  p_btr_ds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    btr_wr |-> (in_dslot && syn_wr && syn_val[DS_BIT]));

  p_modes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |=> (!stat_o[1] && !stat_o[3] && stat_o[2] == $past(stat_o[1]) && stat_o[4] == $past(stat_o[3])));

  p_fatal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> (!pc_wr && !rf_wr && !syn_wr && !btr_wr));

  p_fatal_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> $stable(stat_o));

  p_brk_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_brk) |-> (pc_wr && rf_idx == 5'd16));
endmodule

bind exc_entry_seq exc_entry_chk #(
  .XW(XW), .OFF_IRQ(OFF_IRQ), .OFF_BRK(OFF_BRK), .OFF_EXC(OFF_EXC), .DS_BIT(DS_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_brk(ev_brk),
  .in_dslot(in_dslot), .after_imm(after_imm), .vec_base(vec_base),
  .pc_wr(pc_wr), .pc_nxt(pc_nxt), .rf_wr(rf_wr), .rf_idx(rf_idx),
  .syn_wr(syn_wr), .syn_val(syn_val), .btr_wr(btr_wr), .fatal(fatal), .stat_o(stat_o)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic        clk = 0, rst_n = 0;
  logic        ev_valid = 0, ev_brk = 0, ev_mmu = 0, ev_hwx = 0, ev_irq = 0;
  logic        mmu_prot = 0;
  logic [1:0]  acc_kind = 0;
  logic [4:0]  hwx_code = 0;
  logic [31:0] cur_pc = 0, br_tgt = 0;
  logic [31:0] vec_base = 32'h8000_0000;
  logic        in_dslot = 0, after_imm = 0, br_imm = 0;
  logic        stat_wr = 0;
  logic [6:0]  stat_wdata = 0;
  logic        irq_ok, pc_wr, rf_wr, syn_wr, btr_wr, resv_clr, fatal;
  logic [31:0] pc_nxt, rf_data, syn_val, btr_val;
  logic [4:0]  rf_idx;
  logic [6:0]  stat_o;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_stat(logic [6:0] v);
    @(negedge clk); stat_wr = 1; stat_wdata = v;
    @(posedge clk); #1 stat_wr = 0;
  endtask

  task automatic ev_begin(logic b, logic m, logic h, logic i, logic [31:0] pc,
                          logic ds, logic ai, logic bi);
    @(negedge clk);
    ev_valid = 1; ev_brk = b; ev_mmu = m; ev_hwx = h; ev_irq = i;
    cur_pc = pc; in_dslot = ds; after_imm = ai; br_imm = bi;
    #1;
  endtask

  task automatic ev_end();
    @(posedge clk); #1;
    ev_valid = 0; ev_brk = 0; ev_mmu = 0; ev_hwx = 0; ev_irq = 0;
    in_dslot = 0; after_imm = 0; br_imm = 0;
  endtask

  task automatic t_reset();
    chk("R12 stat", {25'd0, stat_o}, 0);
    chk("R12 strobes", {pc_wr, rf_wr, syn_wr, btr_wr, resv_clr, fatal}, 0);
  endtask

  task automatic t_stat_write();
    set_stat(7'h5a);
    chk("R13 readback", {25'd0, stat_o}, 32'h5a);
    set_stat(7'h00);
  endtask

  task automatic t_irq_blocked();
    set_stat(7'h00);
    ev_begin(0, 0, 0, 1, 32'h100, 0, 0, 0);
    chk("R2 ie clear no strobe", {pc_wr, rf_wr, irq_ok}, 0);
    ev_end();
    chk("R2 ie clear stat", {25'd0, stat_o}, 0);
    set_stat(7'h01);
    ev_begin(0, 0, 0, 1, 32'h100, 1, 0, 0);
    chk("R2 dslot blocks", {pc_wr, irq_ok}, 0);
    ev_end();
    ev_begin(0, 0, 0, 1, 32'h100, 0, 1, 0);
    chk("R2 prefix blocks", {pc_wr, irq_ok}, 0);
    ev_end();
    set_stat(7'h41);
    ev_begin(0, 0, 0, 1, 32'h100, 0, 0, 0);
    chk("R2 eip blocks", {pc_wr, irq_ok}, 0);
    ev_end();
    set_stat(7'h21);
    ev_begin(0, 0, 0, 1, 32'h100, 0, 0, 0);
    chk("R2 bip blocks", {pc_wr, irq_ok}, 0);
    ev_end();
    chk("R2 stat kept", {25'd0, stat_o}, 32'h21);
  endtask

  task automatic t_irq_take();
    set_stat(7'h0b);
    ev_begin(0, 0, 0, 1, 32'h0000_1234, 0, 0, 0);
    chk("R2 irq_ok", {31'd0, irq_ok}, 1);
    chk("R1 irq vector", pc_nxt, 32'h8000_0010);
    chk("R3 reg idx", {27'd0, rf_idx}, 14);
    chk("R3 reg data", rf_data, 32'h1234);
    chk("R9 resv clr", {31'd0, resv_clr}, 1);
    chk("R3 no syndrome", {30'd0, syn_wr, btr_wr}, 0);
    ev_end();
    chk("R9 modes saved, R3 ie off", {25'd0, stat_o}, 32'h14);
  endtask

  task automatic t_brk();
    set_stat(7'h03);
    ev_begin(1, 0, 0, 0, 32'h2000, 0, 0, 0);
    chk("R1 brk vector", pc_nxt, 32'h8000_0018);
    chk("R4 reg idx", {27'd0, rf_idx}, 16);
    chk("R4 reg data", rf_data, 32'h2000);
    ev_end();
    chk("R4 bip set, R9 um saved", {25'd0, stat_o}, 32'h25);
  endtask

  task automatic t_hwx();
    set_stat(7'h00);
    br_tgt = 32'hcafe_0000; hwx_code = 5'd5;
    ev_begin(0, 0, 1, 0, 32'h3000, 1, 0, 0);
    chk("R1 hwx vector", pc_nxt, 32'h8000_0020);
    chk("R5 reg idx", {27'd0, rf_idx}, 17);
    chk("R5 pc+4", rf_data, 32'h3004);
    chk("R5 R8 syndrome", syn_val, 32'h1005);
    chk("R8 btr", {31'd0, btr_wr}, 1);
    chk("R8 btr value", btr_val, 32'hcafe_0000);
    ev_end();
    chk("R5 eip set", {25'd0, stat_o}, 32'h40);
    set_stat(7'h00);
  endtask

  task automatic mmu_case(string req, logic [31:0] pc, logic ds, logic ai, logic bi,
                          logic prot, logic [1:0] kind, logic [31:0] ra, logic [31:0] syn);
    set_stat(7'h00);
    mmu_prot = prot; acc_kind = kind;
    ev_begin(0, 1, 0, 0, pc, ds, ai, bi);
    chk({req, " vector"}, pc_nxt, 32'h8000_0020);
    chk({req, " return"}, rf_data, ra);
    chk({req, " syndrome"}, syn_val, syn);
    chk({req, " btr"}, {31'd0, btr_wr}, {31'd0, ds});
    ev_end();
    chk({req, " eip"}, {25'd0, stat_o}, 32'h40);
  endtask

  task automatic t_mmu();
    mmu_case("R6 R7 plain load miss", 32'h4000, 0, 0, 0, 0, 2'b00, 32'h4000, 16);
    mmu_case("R6 R7 prefix fetch miss", 32'h4000, 0, 1, 0, 0, 2'b10, 32'h3ffc, 17);
    mmu_case("R6 R7 R8 dslot store prot", 32'h4000, 1, 0, 0, 1, 2'b01, 32'h3ffc, 32'h1412);
    mmu_case("R6 R7 R8 dslot prefix fetch prot", 32'h4000, 1, 0, 1, 1, 2'b10, 32'h3ff8, 32'h1013);
    mmu_case("R7 store miss", 32'h5000, 0, 0, 0, 0, 2'b01, 32'h5000, 32'h410);
  endtask

  task automatic t_fatal();
    set_stat(7'h00);
    mmu_prot = 0; acc_kind = 2'b00;
    ev_begin(0, 1, 0, 0, 32'h6000, 0, 0, 0);
    chk("R10 first fault vectors", {31'd0, pc_wr}, 1);
    ev_end();
    ev_begin(0, 1, 0, 0, 32'h6100, 0, 0, 0);
    chk("R10 fatal flagged", {31'd0, fatal}, 1);
    chk("R10 no strobes", {pc_wr, rf_wr, syn_wr, resv_clr}, 0);
    ev_end();
    chk("R10 stat unchanged", {25'd0, stat_o}, 32'h40);
    set_stat(7'h00);
    ev_begin(0, 1, 0, 0, 32'h6200, 0, 0, 0);
    chk("R13 eip clear ends handling", {fatal, pc_wr}, 2'b01);
    ev_end();
    set_stat(7'h00);
  endtask

  task automatic t_prio();
    set_stat(7'h01);
    hwx_code = 5'd3; acc_kind = 2'b00; mmu_prot = 0;
    ev_begin(1, 1, 1, 1, 32'h7000, 0, 0, 0);
    chk("R11 brk wins", {27'd0, rf_idx}, 16);
    chk("R11 brk no syndrome", {31'd0, syn_wr}, 0);
    ev_end();
    set_stat(7'h01);
    ev_begin(0, 1, 1, 1, 32'h7000, 0, 0, 0);
    chk("R11 mmu over hwx return", rf_data, 32'h7000);
    chk("R11 mmu over hwx syndrome", syn_val, 16);
    ev_end();
    set_stat(7'h01);
    ev_begin(0, 0, 1, 1, 32'h7000, 0, 0, 0);
    chk("R11 hwx over irq", {rf_idx, rf_data}, {5'd17, 32'h7004});
    ev_end();
    chk("R11 ie kept", {25'd0, stat_o}, 32'h41);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    t_reset();
    t_stat_write();
    t_irq_blocked();
    t_irq_take();
    t_brk();
    t_hwx();
    t_mmu();
    t_fatal();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule